// File: doc/BRIEF.md
# Fixed-Priority Single-Level Interrupt Arbiter

This block chooses which interrupt a small 8-bit controller core services next. Six sources raise pending flags into it: external input 0, timer 0 overflow, external input 1, PWM overflow, the interval timer and A/D conversion complete. An 8-bit enable register masks these flags. It has one enable bit per source, a global enable bit and one bit with no function. Among the requests that survive the mask, a fixed order picks a single winner. The arbiter then raises a request line to the core and shows the 16-bit vector address of the winning source in the same cycle.

There is only one level and there is no priority register. When the core acknowledges a request, the arbiter enters an in-service state and keeps a copy of the vector it handed out. While it is in service, the request line stays low for every source, so a running handler can never be preempted. A return-from-interrupt pulse from the core ends the in-service state. The core's stack and register saving lie outside this block. The pending flags inside each source also lie outside it.

Top module: `irq_arbiter`

## Requirements
- R1: The sources use these indices: 0 external 0, 1 timer 0, 2 external 1, 3 PWM, 4 interval timer, 5 A/D. When several enabled requests are pending, the lowest index wins.
- R2: The vector address is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x0033 for PWM, 0x001B for the interval timer and 0x002B for A/D. `irq_vec` is 0x0000 when no enabled request is pending.
- R3: The enable register bits are: bit 7 global enable, bit 6 A/D, bit 5 interval timer, bit 3 PWM, bit 2 external 1, bit 1 timer 0, bit 0 external 0. A source takes part in arbitration only if its own bit is 1.
- R4: When bit 7 of the enable register is 0, `irq_req` is 0 and `irq_vec` is 0x0000, whatever the other bits and the pending flags are.
- R5: Bit 4 of the enable register always reads back as 0, and writes to it are ignored. The other bits read back the value last written. A write takes effect on the clock edge where `en_we` is 1.
- R6: When the arbiter is not in service, `irq_req` and `irq_vec` follow the pending flags combinationally in the same cycle.
- R7: On a clock edge with `irq_ack` and `irq_req` both 1, `in_service` becomes 1 and `svc_vec` takes the value of `irq_vec`. An acknowledge while `irq_req` is 0 is ignored.
- R8: While `in_service` is 1, `irq_req` is 0 for any pending source, including a higher-priority one. `svc_vec` does not change.
- R9: A `reti` pulse on a clock edge clears `in_service`. `svc_vec` keeps its value. A `reti` while not in service has no effect.
- R10: After reset the enable register is 0x00, `in_service` is 0, `svc_vec` is 0x0000 and `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Write data for the enable register |
| en_rdata | output | 8 | Enable register contents |
| src_req | input | 6 | Pending flags, one per source index |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the current winner |
| irq_ack | input | 1 | Core accepts the current request |
| reti | input | 1 | Return-from-interrupt pulse |
| in_service | output | 1 | A handler is running |
| svc_vec | output | 16 | Vector latched at the last acknowledge |

## Verification
A wrong mask bit or a wrong priority step shows up in `irq_req` or `irq_vec` in the same cycle as the input pattern that exposes it. Sweeping all 256 enable values against all 64 pending patterns therefore finds such a fault at once. A fault in the in-service state can only be seen one edge after `irq_ack` or `reti`. It shows as a request that stays high during service, a request that does not return after the return pulse, or a latched vector that drifts. The sequences in the bench sample at exactly that edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC   = 6;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int VEC_W  = 16;
    localparam int REG_W  = 8;

    // Enable register bit positions (software-visible layout)
    localparam int EN_GLOBAL = 7;
    localparam int EN_ADC    = 6;
    localparam int EN_ITMR   = 5;
    localparam int EN_RSVD   = 4;
    localparam int EN_PWM    = 3;
    localparam int EN_EXT1   = 2;
    localparam int EN_TMR0   = 1;
    localparam int EN_EXT0   = 0;

    // Source index equals priority rank: lower index wins
    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_PWM  = 3'd3,
        SRC_ITMR = 3'd4,
        SRC_ADC  = 3'd5
    } src_e;

    typedef struct packed {
        logic             active;
        logic [VEC_W-1:0] vec;
    } svc_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
        logic [VEC_W-1:0] v;
        case (s)
            SRC_EXT0: v = 16'h0003;
            SRC_TMR0: v = 16'h000B;
            SRC_EXT1: v = 16'h0013;
            SRC_PWM:  v = 16'h0033;
            SRC_ITMR: v = 16'h001B;
            SRC_ADC:  v = 16'h002B;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic int en_bit_of(input int s);
        int b;
        case (s)
            0:       b = EN_EXT0;
            1:       b = EN_TMR0;
            2:       b = EN_EXT1;
            3:       b = EN_PWM;
            4:       b = EN_ITMR;
            default: b = EN_ADC;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
#(
    parameter int W        = REG_W,
    parameter int RSVD_BIT = EN_RSVD,
    parameter int N        = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q,
    output logic [N-1:0] src_mask
);
    localparam logic [W-1:0] WMASK = ~(W'(1) << RSVD_BIT);

    logic [W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (we) begin
            en_d = wdata & WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign q = en_q;

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign src_mask[i] = en_q[EN_GLOBAL] & en_q[en_bit_of(i)];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_svc_state.sv
module irq_svc_state
    import irq_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          reti,
    input  logic [VW-1:0] vec_in,
    output logic          active,
    output logic [VW-1:0] vec_q
);
    typedef struct packed {
        logic          active;
        logic [VW-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.vec    = vec_in;
        end else if (reti && st_q.active) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign vec_q  = st_q.vec;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [REG_W-1:0] en_wdata,
    output logic [REG_W-1:0] en_rdata,
    input  logic [NSRC-1:0]  src_req,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    input  logic             reti,
    output logic             in_service,
    output logic [VEC_W-1:0] svc_vec
);
    logic [NSRC-1:0]  src_mask;
    logic [NSRC-1:0]  masked;
    logic             any_pend;
    logic [SRC_W-1:0] win_idx;
    logic             active;

    irq_enable_reg #(.W(REG_W), .RSVD_BIT(EN_RSVD), .N(NSRC)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (en_we),
        .wdata    (en_wdata),
        .q        (en_rdata),
        .src_mask (src_mask)
    );

    assign masked = src_req & src_mask;

    irq_prio_pick #(.N(NSRC), .IDX_W(SRC_W)) u_pick (
        .req (masked),
        .any (any_pend),
        .idx (win_idx)
    );

    always_comb begin
        irq_vec = any_pend ? vec_of(win_idx) : '0;
        irq_req = any_pend && !active;
    end

    irq_svc_state #(.VW(VEC_W)) u_svc (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (irq_req && irq_ack),
        .reti   (reti),
        .vec_in (irq_vec),
        .active (active),
        .vec_q  (svc_vec)
    );

    assign in_service = active;

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] en_rdata,
    input logic [NSRC-1:0]  src_req,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic             reti,
    input logic             in_service,
    input logic [VEC_W-1:0] svc_vec
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en_rdata[EN_RSVD] == 1'b0); // R5

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rdata[EN_GLOBAL] |-> (!irq_req && irq_vec == '0)); // R4

    AST_EXT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata[EN_GLOBAL] && en_rdata[EN_EXT0] && src_req[0]) |-> irq_vec == 16'h0003); // R1

    AST_NO_REQ_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |-> !irq_req); // R8

    AST_ACK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> (in_service && svc_vec == $past(irq_vec))); // R7

    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !reti) |=> (in_service && $stable(svc_vec))); // R8

    AST_RETI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && reti) |=> (!in_service && $stable(svc_vec))); // R9
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_rdata   (en_rdata),
    .src_req    (src_req),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_ack    (irq_ack),
    .reti       (reti),
    .in_service (in_service),
    .svc_vec    (svc_vec)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_we = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [7:0]  en_rdata;
    logic [5:0]  src_req = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;
    logic        in_service;
    logic [15:0] svc_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .src_req(src_req), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .reti(reti),
        .in_service(in_service), .svc_vec(svc_vec)
    );

    function automatic logic [15:0] exp_vec_of(input int s);
        case (s)
            0: return 16'h0003;
            1: return 16'h000B;
            2: return 16'h0013;
            3: return 16'h0033;
            4: return 16'h001B;
            5: return 16'h002B;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [5:0] exp_mask(input logic [7:0] e);
        logic [5:0] m;
        m = {e[6], e[5], e[3], e[2], e[1], e[0]};
        return e[7] ? m : 6'b0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_en(input logic [7:0] v);
        @(negedge clk);
        en_we = 1'b1;
        en_wdata = v;
        tick();
        en_we = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #23;
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 en_rdata", 32'(en_rdata), 32'h00);
        chk("R10 in_service", 32'(in_service), 32'h0);
        chk("R10 svc_vec", 32'(svc_vec), 32'h0);
        chk("R10 irq_req", 32'(irq_req), 32'h0);

        // Exhaustive sweep: R1 R2 R3 R4 R5 R6
        for (int e = 0; e < 256; e++) begin
            write_en(8'(e));
            chk("R5 readback", 32'(en_rdata), 32'(8'(e) & 8'hEF));
            for (int s = 0; s < 64; s++) begin
                logic [5:0]  m;
                logic        er;
                logic [15:0] ev;
                @(negedge clk);
                src_req = 6'(s);
                #1;
                m  = 6'(s) & exp_mask(8'(e) & 8'hEF);
                er = |m;
                ev = 16'h0;
                for (int k = 5; k >= 0; k--) begin
                    if (m[k]) ev = exp_vec_of(k);
                end
                chk("R1/R2/R3/R4/R6 req+vec", {15'h0, irq_req, irq_vec}, {15'h0, er, ev});
            end
        end

        // R7: acknowledge latches PWM (3) over A/D (5)
        write_en(8'hFF);
        @(negedge clk);
        src_req = 6'b101000;
        #1;
        chk("R2 pwm vec", 32'(irq_vec), 32'h0033);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R7 in_service set", 32'(in_service), 32'h1);
        chk("R7 svc_vec", 32'(svc_vec), 32'h0033);
        // R8: higher priority arrives, no preemption
        src_req = 6'b101001;
        #1;
        chk("R8 req low in service", 32'(irq_req), 32'h0);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R8 svc_vec held", 32'(svc_vec), 32'h0033);
        chk("R8 still in service", 32'(in_service), 32'h1);
        // R9: return clears, ext0 now requests
        reti = 1'b1;
        tick();
        reti = 1'b0;
        chk("R9 in_service cleared", 32'(in_service), 32'h0);
        chk("R9 svc_vec kept", 32'(svc_vec), 32'h0033);
        chk("R9 req returns ext0", {15'h0, irq_req, irq_vec}, {15'h0, 1'b1, 16'h0003});
        // R9: reti while idle has no effect
        reti = 1'b1;
        tick();
        reti = 1'b0;
        chk("R9 idle reti", {15'h0, in_service, svc_vec}, {15'h0, 1'b0, 16'h0033});
        // R7: ack with no request is ignored
        write_en(8'h7F);
        @(negedge clk);
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R7 ack ignored", 32'(in_service), 32'h0);
        // R7: ack of interval timer alone
        write_en(8'hA0);
        @(negedge clk);
        src_req = 6'b110000;
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
        chk("R7 itmr latch", {15'h0, in_service, svc_vec}, {15'h0, 1'b1, 16'h001B});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule